// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block keeps a table of eight-byte buffer descriptors in an internal memory that the host can read and write at any time. The table is split into two rings by a programmable boundary. The first entries form the transmit ring and the entries after them form the receive ring. Each descriptor is two 32-bit words: a status/control word followed by a buffer address word.

For transmit, the sequencer polls the current transmit descriptor until its ready bit is set. It then presents the buffer address, frame length and per-frame options on a frame-request port and waits for completion. It writes the returned completion flags back into the same status word, clears ready and moves on.

For receive, each incoming frame notification claims the current receive descriptor if it is marked empty. The sequencer writes back the frame length and error flags and clears empty. If the descriptor is not empty, the frame is dropped and a busy event is raised.

Event pulses report frame completion and frame errors. The sequencer does not move payload data.

Top module: `bdr_seq`

## Requirements
- R1: After reset, tx_req, rx_ack and all event outputs are low, and the transmit-count register reads 0.
- R2: The transmit-count register is at byte offset 0x000. A write above NUM_BD stores NUM_BD. Any write to it returns both ring pointers to the first entry of their rings.
- R3: Descriptor i occupies byte offset 0x400+8*i: the status word at +0 and the address word at +4. A host read returns data one cycle after the request.
- R4: A transmit descriptor with ready (bit 15) set starts a request. The request carries the address word, the length from bits 31:16, pad from bit 12 and CRC from bit 11. tx_req holds steady until tx_done. A descriptor without ready starts nothing.
- R5: On transmit completion, status bits 8:0 are replaced by tx_status and bit 15 is cleared. All other bits are kept.
- R6: A transmit completion with interrupt-request (bit 14) set pulses ev_tx_err if tx_status has any of bits 8, 3, 2 or 0 set, and pulses ev_tx_done otherwise. With bit 14 clear, neither pulses.
- R7: A receive frame that finds the current receive descriptor empty (bit 15) causes three things. Bits 31:16 are written with rx_len, bit 8 with rx_ctrl and bits 7:0 with rx_err. Bit 15 is cleared while bits 14:9 are kept. rx_ack pulses once.
- R8: A receive completion with bit 14 set pulses ev_rx_err if rx_err is non-zero, and pulses ev_rx_done otherwise. With bit 14 clear, neither pulses.
- R9: When the current receive descriptor is not empty, or the receive ring has no entries, the frame is dropped. rx_ack and ev_rx_busy pulse, the descriptor is unchanged and the pointer does not move.
- R10: After a descriptor with wrap (bit 13) set, or after the last entry of its ring, the pointer returns to the first entry of that ring.
- R11: Receive descriptors are entries transmit-count to NUM_BD-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read |
| tx_req | output | 1 | Transmit frame request pending |
| tx_addr | output | 32 | Buffer address of the pending frame |
| tx_len | output | 16 | Length of the pending frame |
| tx_pad | output | 1 | Pad option of the pending frame |
| tx_crc | output | 1 | CRC option of the pending frame |
| tx_done | input | 1 | Transmit completion pulse |
| tx_status | input | 9 | Completion flags returned with tx_done |
| rx_valid | input | 1 | Incoming frame notification, held until rx_ack |
| rx_len | input | 16 | Received length including frame check sequence |
| rx_err | input | 8 | Receive error flags |
| rx_ctrl | input | 1 | Frame was a control frame |
| rx_ack | output | 1 | Frame notification consumed |
| ev_tx_done | output | 1 | Transmit done event pulse |
| ev_tx_err | output | 1 | Transmit error event pulse |
| ev_rx_done | output | 1 | Receive done event pulse |
| ev_rx_err | output | 1 | Receive error event pulse |
| ev_rx_busy | output | 1 | Receive dropped event pulse |

## Verification
Host readback is due exactly one cycle after the request edge, so every descriptor check samples at the falling edge that follows that clock edge.

The transmit request, completion writeback and receive acknowledge depend on how much host traffic delays the sequencer. The bench therefore does not count fixed cycles for these results. Instead, it waits for tx_req and rx_ack as handshakes. Expected transmit requests sit in a queue that a monitor pops the moment tx_req appears.

Event pulses are tallied every cycle and compared with scoreboard totals a few cycles after each handshake. Descriptor contents are read back only after the writeback cycle has passed.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int unsigned LEN_LSB = 16;
  localparam int unsigned B_OWN   = 15;  // ready (transmit) / empty (receive)
  localparam int unsigned B_IRQ   = 14;
  localparam int unsigned B_WRAP  = 13;
  localparam int unsigned B_PAD   = 12;
  localparam int unsigned B_CRC   = 11;
  // completion flags that count as a transmit error: underrun, limit, late collision, carrier lost
  localparam logic [8:0] TX_ERR_MASK = 9'h10D;

  typedef enum logic [3:0] {
    S_IDLE, S_TX_RD, S_TX_CHK, S_TX_ARD, S_TX_ACAP, S_TX_WAIT, S_TX_WB,
    S_RX_RD, S_RX_CHK, S_RX_WB, S_RX_DROP
  } seq_state_e;
endpackage

// File: rtl/bdr_mem.sv
module bdr_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bdr_ring_ptr.sv
module bdr_ring_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             wrap_flag,
  input  logic [IDX_W:0]   count,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W:0] nxt_wide;
  assign nxt_wide = {1'b0, idx} + (IDX_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || clr)
      idx <= '0;
    else if (adv) begin
      if (wrap_flag || nxt_wide >= count) idx <= '0;
      else                                idx <= nxt_wide[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/bdr_seq.sv
module bdr_seq
  import bdr_pkg::*;
#(
  parameter int NUM_BD     = 128,
  parameter int HOST_AW    = 12,
  parameter int TABLE_BASE = 'h400,
  parameter int CNT_OFFS   = 'h000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               tx_req,
  output logic [31:0]        tx_addr,
  output logic [15:0]        tx_len,
  output logic               tx_pad,
  output logic               tx_crc,
  input  logic               tx_done,
  input  logic [8:0]         tx_status,
  input  logic               rx_valid,
  input  logic [15:0]        rx_len,
  input  logic [7:0]         rx_err,
  input  logic               rx_ctrl,
  output logic               rx_ack,
  output logic               ev_tx_done,
  output logic               ev_tx_err,
  output logic               ev_rx_done,
  output logic               ev_rx_err,
  output logic               ev_rx_busy
);
  localparam int IDX_W   = $clog2(NUM_BD);
  localparam int CNT_W   = IDX_W + 1;
  localparam int MEM_AW  = IDX_W + 1;
  localparam int TBL_END = TABLE_BASE + 8 * NUM_BD;

  // host decode
  logic              host_tbl, host_cnt;
  logic [MEM_AW-1:0] host_word;
  assign host_tbl  = (32'(host_addr) >= TABLE_BASE) && (32'(host_addr) < TBL_END);
  assign host_cnt  = (32'(host_addr) == CNT_OFFS);
  assign host_word = MEM_AW'((host_addr - HOST_AW'(TABLE_BASE)) >> 2);

  // transmit-count register
  logic [CNT_W-1:0] txcnt_q, rxcnt;
  logic             cnt_wr;
  assign cnt_wr = host_req && host_we && host_cnt;
  assign rxcnt  = CNT_W'(NUM_BD) - txcnt_q;

  always_ff @(posedge clk) begin
    if (rst) txcnt_q <= '0;
    else if (cnt_wr)
      txcnt_q <= (host_wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : host_wdata[CNT_W-1:0];
  end

  // descriptor memory with host priority
  logic              eng_we, eng_re;
  logic [MEM_AW-1:0] eng_addr;
  logic [31:0]       eng_wdata;
  logic              mem_we, mem_re;
  logic [MEM_AW-1:0] mem_addr;
  logic [31:0]       mem_wdata, mem_q;

  assign mem_we    = host_req ? (host_we && host_tbl)  : eng_we;
  assign mem_re    = host_req ? (!host_we && host_tbl) : eng_re;
  assign mem_addr  = host_req ? host_word : eng_addr;
  assign mem_wdata = host_req ? host_wdata : eng_wdata;

  bdr_mem #(.DW(32), .DEPTH(2 * NUM_BD)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_addr), .rdata(mem_q)
  );

  logic rd_tbl_q, rd_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tbl_q <= 1'b0;
      rd_cnt_q <= 1'b0;
    end else begin
      rd_tbl_q <= host_req && !host_we && host_tbl;
      rd_cnt_q <= host_req && !host_we && host_cnt;
    end
  end
  assign host_rdata = rd_tbl_q ? mem_q : (rd_cnt_q ? 32'(txcnt_q) : 32'h0);

  // ring pointers
  logic             tx_adv, rx_adv;
  logic [IDX_W-1:0] tx_idx, rx_idx, rx_ent;
  logic             wrap_q;

  bdr_ring_ptr #(.IDX_W(IDX_W)) u_tx_ptr (
    .clk(clk), .rst(rst), .clr(cnt_wr), .adv(tx_adv),
    .wrap_flag(wrap_q), .count(txcnt_q), .idx(tx_idx)
  );
  bdr_ring_ptr #(.IDX_W(IDX_W)) u_rx_ptr (
    .clk(clk), .rst(rst), .clr(cnt_wr), .adv(rx_adv),
    .wrap_flag(wrap_q), .count(rxcnt), .idx(rx_idx)
  );
  assign rx_ent = IDX_W'(txcnt_q + CNT_W'(rx_idx));

  // sequencer
  seq_state_e       state, nxt;
  logic [IDX_W-1:0] ent_q;
  logic [15:0]      keep_hi;
  logic [5:0]       keep_mid;   // bits 14:9 of the armed status word
  logic [8:0]       tstat_q;
  logic [31:0]      tx_wb, rx_wb;

  assign wrap_q = keep_mid[B_WRAP-9];
  assign tx_wb  = {keep_hi, 1'b0, keep_mid, tstat_q};
  assign rx_wb  = {rx_len, 1'b0, keep_mid, rx_ctrl, rx_err};

  always_comb begin
    nxt = state; eng_we = 1'b0; eng_re = 1'b0; eng_addr = '0; eng_wdata = '0;
    tx_adv = 1'b0; rx_adv = 1'b0;
    case (state)
      S_IDLE:    if (rx_valid) nxt = S_RX_RD;
                 else if (txcnt_q != '0) nxt = S_TX_RD;
      S_TX_RD:   if (!host_req) begin
                   eng_re = 1'b1; eng_addr = {tx_idx, 1'b0}; nxt = S_TX_CHK;
                 end
      S_TX_CHK:  nxt = mem_q[B_OWN] ? S_TX_ARD : S_IDLE;
      S_TX_ARD:  if (!host_req) begin
                   eng_re = 1'b1; eng_addr = {ent_q, 1'b1}; nxt = S_TX_ACAP;
                 end
      S_TX_ACAP: nxt = S_TX_WAIT;
      S_TX_WAIT: if (tx_done) nxt = S_TX_WB;
      S_TX_WB:   if (!host_req) begin
                   eng_we = 1'b1; eng_addr = {ent_q, 1'b0}; eng_wdata = tx_wb;
                   tx_adv = 1'b1; nxt = S_IDLE;
                 end
      S_RX_RD:   if (rxcnt == '0) nxt = S_RX_DROP;
                 else if (!host_req) begin
                   eng_re = 1'b1; eng_addr = {rx_ent, 1'b0}; nxt = S_RX_CHK;
                 end
      S_RX_CHK:  nxt = mem_q[B_OWN] ? S_RX_WB : S_RX_DROP;
      S_RX_WB:   if (!host_req) begin
                   eng_we = 1'b1; eng_addr = {ent_q, 1'b0}; eng_wdata = rx_wb;
                   rx_adv = 1'b1; nxt = S_IDLE;
                 end
      S_RX_DROP: nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; ent_q <= '0; keep_hi <= '0; keep_mid <= '0; tstat_q <= '0;
      tx_req <= 1'b0; tx_addr <= '0; tx_len <= '0; tx_pad <= 1'b0; tx_crc <= 1'b0;
      rx_ack <= 1'b0; ev_tx_done <= 1'b0; ev_tx_err <= 1'b0;
      ev_rx_done <= 1'b0; ev_rx_err <= 1'b0; ev_rx_busy <= 1'b0;
    end else begin
      state <= nxt;
      rx_ack <= 1'b0; ev_tx_done <= 1'b0; ev_tx_err <= 1'b0;
      ev_rx_done <= 1'b0; ev_rx_err <= 1'b0; ev_rx_busy <= 1'b0;
      case (state)
        S_TX_RD: if (!host_req) ent_q <= tx_idx;
        S_RX_RD: if (!host_req) ent_q <= rx_ent;
        S_TX_CHK, S_RX_CHK: begin
          keep_hi  <= mem_q[31:LEN_LSB];
          keep_mid <= mem_q[14:9];
        end
        S_TX_ACAP: begin
          tx_addr <= mem_q;
          tx_len  <= keep_hi;
          tx_pad  <= keep_mid[B_PAD-9];
          tx_crc  <= keep_mid[B_CRC-9];
          tx_req  <= 1'b1;
        end
        S_TX_WAIT: if (tx_done) begin
          tx_req  <= 1'b0;
          tstat_q <= tx_status;
        end
        S_TX_WB: if (!host_req && keep_mid[B_IRQ-9]) begin
          ev_tx_err  <= |(tstat_q & TX_ERR_MASK);
          ev_tx_done <= ~|(tstat_q & TX_ERR_MASK);
        end
        S_RX_WB: if (!host_req) begin
          rx_ack <= 1'b1;
          if (keep_mid[B_IRQ-9]) begin
            ev_rx_err  <= |rx_err;
            ev_rx_done <= ~|rx_err;
          end
        end
        S_RX_DROP: begin
          rx_ack     <= 1'b1;
          ev_rx_busy <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bdr_seq_chk.sv
module bdr_seq_chk #(
  parameter int NUM_BD = 128,
  localparam int CNT_W = $clog2(NUM_BD) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_req,
  input logic             tx_done,
  input logic [31:0]      tx_addr,
  input logic             rx_ack,
  input logic             ev_tx_done,
  input logic             ev_tx_err,
  input logic             ev_rx_done,
  input logic             ev_rx_err,
  input logic             ev_rx_busy,
  input logic [CNT_W-1:0] txcnt
);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    txcnt <= CNT_W'(NUM_BD));

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    tx_req && !tx_done |=> tx_req && $stable(tx_addr));

  p_ev_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_tx_done, ev_tx_err, ev_rx_done, ev_rx_err, ev_rx_busy}));

  p_txev_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_done || ev_tx_err) |-> !tx_req);

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rx_ack |=> !rx_ack);

  p_rxev_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_done || ev_rx_err) |-> rx_ack);

  p_busy_ack_r9: assert property (@(posedge clk) disable iff (rst)
    ev_rx_busy |-> rx_ack);
endmodule

bind bdr_seq bdr_seq_chk #(.NUM_BD(NUM_BD)) u_chk (
  .clk(clk), .rst(rst), .tx_req(tx_req), .tx_done(tx_done), .tx_addr(tx_addr),
  .rx_ack(rx_ack), .ev_tx_done(ev_tx_done), .ev_tx_err(ev_tx_err),
  .ev_rx_done(ev_rx_done), .ev_rx_err(ev_rx_err), .ev_rx_busy(ev_rx_busy),
  .txcnt(txcnt_q)
);

// File: tb/bdr_seq_bench.sv
module bdr_seq_bench;
  localparam int NUM_BD = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        tx_req, tx_pad, tx_crc, tx_done = 1'b0;
  logic [31:0] tx_addr;
  logic [15:0] tx_len;
  logic [8:0]  tx_status = '0;
  logic        rx_valid = 1'b0, rx_ctrl = 1'b0, rx_ack;
  logic [15:0] rx_len = '0;
  logic [7:0]  rx_err = '0;
  logic        ev_tx_done, ev_tx_err, ev_rx_done, ev_rx_err, ev_rx_busy;

  always #4 clk = ~clk;

  bdr_seq #(.NUM_BD(NUM_BD)) u_bdr_seq (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_pad(tx_pad),
    .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err), .rx_ctrl(rx_ctrl),
    .rx_ack(rx_ack), .ev_tx_done(ev_tx_done), .ev_tx_err(ev_tx_err),
    .ev_rx_done(ev_rx_done), .ev_rx_err(ev_rx_err), .ev_rx_busy(ev_rx_busy)
  );

  int checks = 0, errors = 0;
  int n_txd = 0, n_txe = 0, n_rxd = 0, n_rxe = 0, n_busy = 0;
  int x_txd = 0, x_txe = 0, x_rxd = 0, x_rxe = 0, x_busy = 0;

  typedef struct {
    logic [31:0] addr;
    logic [15:0] len;
    logic        pad;
    logic        crc;
    logic [8:0]  st;
  } tx_item_t;
  tx_item_t tx_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] desc(input int i);
    return 32'h400 + 32'(8 * i);
  endfunction

  function automatic logic [31:0] txw(input int len, input bit irq, input bit wrap,
                                      input bit pad, input bit crc, input bit rdy);
    return {16'(len), rdy, irq, wrap, pad, crc, 11'h0};
  endfunction

  function automatic logic [31:0] rxw(input bit irq, input bit wrap);
    return {16'h0, 1'b1, irq, wrap, 13'h0};
  endfunction

  task automatic hwr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a[11:0]; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a[11:0];
    @(negedge clk);
    d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    hrd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic rx_frame(input int len, input logic [7:0] err, input bit ctrl);
    @(negedge clk);
    rx_valid = 1'b1; rx_len = 16'(len); rx_err = err; rx_ctrl = ctrl;
    do @(negedge clk); while (!rx_ack);
    rx_valid = 1'b0;
  endtask

  task automatic push_tx(input logic [31:0] a, input int len, input bit pad,
                         input bit crc, input logic [8:0] st);
    tx_item_t it;
    it.addr = a; it.len = 16'(len); it.pad = pad; it.crc = crc; it.st = st;
    tx_q.push_back(it);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 2000 && tx_q.size() != 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(tag, 32'(tx_q.size()), 32'd0);
  endtask

  task automatic ev_chk(input string tag);
    repeat (3) @(negedge clk);
    chk({tag, " tx done events"}, 32'(n_txd), 32'(x_txd));
    chk({tag, " tx error events"}, 32'(n_txe), 32'(x_txe));
    chk({tag, " rx done events"}, 32'(n_rxd), 32'(x_rxd));
    chk({tag, " rx error events"}, 32'(n_rxe), 32'(x_rxe));
    chk({tag, " busy events"}, 32'(n_busy), 32'(x_busy));
  endtask

  // event tally
  always @(negedge clk) begin
    if (!rst) begin
      n_txd += int'(ev_tx_done);
      n_txe += int'(ev_tx_err);
      n_rxd += int'(ev_rx_done);
      n_rxe += int'(ev_rx_err);
      n_busy += int'(ev_rx_busy);
    end
  end

  // transmit monitor: pops the expected request and answers with its completion flags
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tx_req && !tx_done) begin
        if (tx_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected request actual addr %h expected none", tx_addr);
          tx_status = 9'h0;
        end else begin
          tx_item_t it;
          it = tx_q.pop_front();
          chk("R4 request address", tx_addr, it.addr);
          chk("R4 request length", 32'(tx_len), 32'(it.len));
          chk("R4 request pad", 32'(tx_pad), 32'(it.pad));
          chk("R4 request crc", 32'(tx_crc), 32'(it.crc));
          tx_status = it.st;
        end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_req", 32'(tx_req), 32'd0);
    chk("R1 rx_ack", 32'(rx_ack), 32'd0);
    chk("R1 events", 32'({ev_tx_done, ev_tx_err, ev_rx_done, ev_rx_err, ev_rx_busy}), 32'd0);
    rd_chk("R1 count reset", 32'h0, 32'd0);

    // R3 table access, R2 clamp
    hwr(desc(0), 32'h0);
    hwr(desc(0) + 4, 32'h1000);
    rd_chk("R3 address word", desc(0) + 4, 32'h1000);
    hwr(32'h0, 32'h200);
    rd_chk("R2 clamp", 32'h0, 32'(NUM_BD));

    // R9 no receive entries: drop
    rx_frame(64, 8'h0, 1'b0);
    x_busy++;
    ev_chk("R9 empty ring");

    // ring setup: transmit entries 0..3, receive from 4
    hwr(desc(1) + 4, 32'h2000);
    hwr(desc(1), txw(100, 1, 1, 0, 1, 1));
    hwr(desc(2), 32'h0);
    hwr(desc(3), 32'h0);
    hwr(desc(4), rxw(1, 0));
    hwr(desc(5), rxw(1, 1));
    hwr(desc(6), rxw(1, 0));
    hwr(32'h0, 32'd4);
    rd_chk("R2 count write", 32'h0, 32'd4);

    // R4/R5/R6 transmit two frames
    push_tx(32'h1000, 60, 1, 1, 9'h020);
    push_tx(32'h2000, 100, 0, 1, 9'h108);
    x_txd++; x_txe++;
    hwr(desc(0), txw(60, 1, 0, 1, 1, 1));
    drain("R4 two frames served");
    ev_chk("R6 irq set");
    rd_chk("R5 entry0 writeback", desc(0), txw(60, 1, 0, 1, 1, 0) | 32'h020);
    rd_chk("R5 entry1 writeback", desc(1), txw(100, 1, 1, 0, 1, 0) | 32'h108);

    // R10 wrap flag returns to entry 0; R6 irq clear gives no event
    push_tx(32'h1000, 64, 0, 0, 9'h004);
    hwr(desc(0), txw(64, 0, 0, 0, 0, 1));
    drain("R10 tx wrap to first entry");
    ev_chk("R6 irq clear");
    rd_chk("R5 entry0 second writeback", desc(0), txw(64, 0, 0, 0, 0, 0) | 32'h004);

    // R7/R8/R11 receive
    rx_frame(64, 8'h00, 1'b0);
    x_rxd++;
    ev_chk("R8 rx done");
    rd_chk("R11 first rx entry", desc(4), {16'd64, 1'b0, 1'b1, 14'h0});
    rx_frame(1518, 8'h02, 1'b1);
    x_rxe++;
    ev_chk("R8 rx error");
    rd_chk("R7 rx writeback", desc(5), {16'd1518, 1'b0, 1'b1, 1'b1, 4'h0, 1'b1, 8'h02});
    rx_frame(80, 8'h00, 1'b0);
    x_busy++;
    ev_chk("R9 not empty");
    rd_chk("R9 descriptor unchanged", desc(4), {16'd64, 1'b0, 1'b1, 14'h0});
    rd_chk("R10 rx wrap skipped entry6", desc(6), rxw(1, 0));
    hwr(desc(4), rxw(0, 0));
    rx_frame(90, 8'h10, 1'b0);
    ev_chk("R8 irq clear");
    rd_chk("R9 pointer held then R7", desc(4), {16'd90, 1'b0, 1'b0, 1'b0, 5'h0, 8'h10});

    // R10 end of ring without wrap flag; R2 pointer reset
    hwr(desc(126), rxw(1, 0));
    hwr(desc(127), rxw(1, 0));
    hwr(32'h0, 32'd126);
    rx_frame(70, 8'h0, 1'b0);
    rx_frame(71, 8'h0, 1'b0);
    hwr(desc(126), rxw(1, 0));
    rx_frame(72, 8'h0, 1'b0);
    x_rxd += 3;
    ev_chk("R10 end of ring");
    rd_chk("R10 ring restart", desc(126), {16'd72, 1'b0, 1'b1, 14'h0});
    rd_chk("R11 last entry", desc(127), {16'd71, 1'b0, 1'b1, 14'h0});
    chk("R4 no stray requests", 32'(tx_q.size()), 32'd0);

    finish_run();
  end
endmodule